// File: doc/BRIEF.md
# DDR2 Command Spacing Monitor

This block watches the command pins of a DDR2 memory interface from the controller side. On every rising clock edge it decodes the command, keeps the cycle counts since earlier related commands, and flags any command that arrives sooner than the minimum spacing in clock cycles. The rules covered are:

- activate after precharge to the same bank
- back-to-back column commands
- write-to-read turnaround
- spacing after a mode register set
- minimum CKE pulse width in both polarities
- activate after a write with auto-precharge

Analog limits such as setup, hold, skew and strobe timing are outside its scope.

Cycle limits come from elaboration parameters. A time in picoseconds is divided by the average clock period and rounded up to a whole cycle. With a 15000 ps precharge time and a 3000 ps clock, the activate spacing is 5 cycles. A clock period outside 3000..8000 ps stops elaboration. Each rule has its own one-cycle violation pulse and its own bit in a sticky error register, and only reset clears that register.

CKE supervision is a small state machine with these states:

- `CK_INIT`: the first cycle after reset. It moves to `CK_HIGH_FREE` or `CK_LOW_FREE` according to the sampled CKE level, with no check.
- `CK_*_HOLD`: entered on a CKE edge. The monitor stays in the hold state while the level is younger than the minimum width.
- Hold to free: taken when the level reaches its minimum width. In `CK_*_FREE` any edge is legal and enters the opposite hold state.
- Hold to the opposite hold: an edge seen while in a hold state raises the CKE violation.

Top module: `ddr2_spacing_monitor`

## Requirements
- R1: A command is decoded only when CKE is high and chip select (active low) is low. The encodings of {row strobe, column strobe, write enable}, all active low, are: 000 mode register set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read. Codes 110 and 111 are no command. Deselect, no-command codes and anything presented while CKE is low raise no command rule.
- R2: An activate to bank b raises the precharge rule (bit 0) if it comes fewer than ceil(TRP_PS/CK_PERIOD_PS) cycles after a precharge to bank b. Exactly that many cycles is legal, and precharges to other banks have no effect.
- R3: A precharge with the auto-precharge/all-banks flag set arms the precharge rule of every bank.
- R4: A read or write fewer than 2 cycles after a previous read or write raises the column rule (bit 1).
- R5: A read fewer than max(2, ceil(TWTR_PS/CK_PERIOD_PS)) cycles after a write raises the turnaround rule (bit 2).
- R6: Any command fewer than 2 cycles after a mode register set raises the mode rule (bit 3).
- R7: A CKE edge fewer than 3 cycles after the previous CKE edge raises the CKE rule (bit 4). This applies to both polarities. The level held at reset release is not checked.
- R8: An activate to bank b fewer than WR_CYC + ceil(TRP_PS/CK_PERIOD_PS) cycles after a write with the auto-precharge flag to bank b raises the auto-precharge rule (bit 5).
- R9: Each violation bit is high for exactly the one cycle after the offending sampling edge. The same bit is then set in the sticky register, which holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| ap | input | 1 | Auto-precharge / all-banks address bit |
| viol | output | 6 | One-cycle violation pulse per rule |
| err_sticky | output | 6 | Sticky error bits, cleared by reset |

## Verification
The bench builds the block with its default parameters: a 3000 ps clock, a 15000 ps precharge time, a 7500 ps turnaround time and 3 write recovery cycles. These give limits of 5, 3 and 8 cycles. The turnaround limit of 3 lies above the 2-cycle floor, so a read two cycles after a write separates the turnaround rule from the column rule. The 8-cycle auto-precharge window exposes off-by-one errors at its boundary, and the same holds for the 5-cycle activate window.

// File: rtl/ddr2_mon_pkg.sv
package ddr2_mon_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_MRS,
        CMD_REF,
        CMD_PRE,
        CMD_ACT,
        CMD_WR,
        CMD_RD
    } cmd_e;

    typedef enum logic [2:0] {
        CK_INIT,
        CK_LOW_HOLD,
        CK_LOW_FREE,
        CK_HIGH_HOLD,
        CK_HIGH_FREE
    } cke_st_e;

    localparam int RULE_RP    = 0;
    localparam int RULE_CCD   = 1;
    localparam int RULE_WTR   = 2;
    localparam int RULE_MRD   = 3;
    localparam int RULE_CKE   = 4;
    localparam int RULE_DAL   = 5;
    localparam int NUM_RULES  = 6;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode
    import ddr2_mon_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_NONE;
        if (cke && !cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = CMD_REF;
                3'b010:  cmd = CMD_PRE;
                3'b011:  cmd = CMD_ACT;
                3'b100:  cmd = CMD_WR;
                3'b101:  cmd = CMD_RD;
                default: cmd = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ddr2_bank_timers.sv
module ddr2_bank_timers
    import ddr2_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2,
    parameter int CW        = 4,
    parameter int RP_CYC    = 5,
    parameter int DAL_CYC   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  cmd_e            cmd,
    input  logic [BA_W-1:0] ba,
    input  logic            ap,
    output logic            rp_hit,
    output logic            dal_hit
);

    localparam logic [CW-1:0] RP_LOAD  = CW'(RP_CYC - 1);
    localparam logic [CW-1:0] DAL_LOAD = CW'(DAL_CYC - 1);

    logic [NUM_BANKS-1:0] rp_vec;
    logic [NUM_BANKS-1:0] dal_vec;

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        logic [CW-1:0] rp_cnt;
        logic [CW-1:0] dal_cnt;
        logic          sel;

        assign sel = (ba == BA_W'(gi));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rp_cnt <= '0;
            end else if (cmd == CMD_PRE && (sel || ap)) begin
                rp_cnt <= RP_LOAD;
            end else if (rp_cnt != '0) begin
                rp_cnt <= rp_cnt - 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dal_cnt <= '0;
            end else if (cmd == CMD_WR && sel && ap) begin
                dal_cnt <= DAL_LOAD;
            end else if (dal_cnt != '0) begin
                dal_cnt <= dal_cnt - 1'b1;
            end
        end

        assign rp_vec[gi]  = (cmd == CMD_ACT) && sel && (rp_cnt != '0);
        assign dal_vec[gi] = (cmd == CMD_ACT) && sel && (dal_cnt != '0);
    end

    assign rp_hit  = |rp_vec;
    assign dal_hit = |dal_vec;

endmodule

// File: rtl/ddr2_global_timers.sv
module ddr2_global_timers
    import ddr2_mon_pkg::*;
#(
    parameter int CW      = 4,
    parameter int CCD_CYC = 2,
    parameter int WTR_CYC = 3,
    parameter int MRD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    output logic ccd_hit,
    output logic wtr_hit,
    output logic mrd_hit
);

    localparam logic [CW-1:0] CCD_LOAD = CW'(CCD_CYC - 1);
    localparam logic [CW-1:0] WTR_LOAD = CW'(WTR_CYC - 1);
    localparam logic [CW-1:0] MRD_LOAD = CW'(MRD_CYC - 1);

    logic [CW-1:0] ccd_cnt;
    logic [CW-1:0] wtr_cnt;
    logic [CW-1:0] mrd_cnt;
    logic          is_col;

    assign is_col = (cmd == CMD_WR) || (cmd == CMD_RD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccd_cnt <= '0;
        end else if (is_col) begin
            ccd_cnt <= CCD_LOAD;
        end else if (ccd_cnt != '0) begin
            ccd_cnt <= ccd_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wtr_cnt <= '0;
        end else if (cmd == CMD_WR) begin
            wtr_cnt <= WTR_LOAD;
        end else if (wtr_cnt != '0) begin
            wtr_cnt <= wtr_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mrd_cnt <= '0;
        end else if (cmd == CMD_MRS) begin
            mrd_cnt <= MRD_LOAD;
        end else if (mrd_cnt != '0) begin
            mrd_cnt <= mrd_cnt - 1'b1;
        end
    end

    assign ccd_hit = is_col && (ccd_cnt != '0);
    assign wtr_hit = (cmd == CMD_RD) && (wtr_cnt != '0);
    assign mrd_hit = (cmd != CMD_NONE) && (mrd_cnt != '0);

endmodule

// File: rtl/ddr2_cke_fsm.sv
module ddr2_cke_fsm
    import ddr2_mon_pkg::*;
#(
    parameter int MIN_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    output logic cke_hit
);

    localparam int            HW       = $clog2(MIN_CYC + 1);
    localparam logic [HW-1:0] HOLD_END = HW'(MIN_CYC - 1);

    cke_st_e       state, state_nxt;
    logic [HW-1:0] hold,  hold_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CK_INIT;
            hold  <= '0;
        end else begin
            state <= state_nxt;
            hold  <= hold_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        hold_nxt  = hold;
        cke_hit   = 1'b0;
        unique case (state)
            CK_INIT: begin
                state_nxt = cke ? CK_HIGH_FREE : CK_LOW_FREE;
            end
            CK_LOW_HOLD: begin
                if (cke) begin
                    cke_hit   = 1'b1;
                    state_nxt = CK_HIGH_HOLD;
                    hold_nxt  = HW'(1);
                end else if (hold == HOLD_END) begin
                    state_nxt = CK_LOW_FREE;
                end else begin
                    hold_nxt = hold + 1'b1;
                end
            end
            CK_LOW_FREE: begin
                if (cke) begin
                    state_nxt = CK_HIGH_HOLD;
                    hold_nxt  = HW'(1);
                end
            end
            CK_HIGH_HOLD: begin
                if (!cke) begin
                    cke_hit   = 1'b1;
                    state_nxt = CK_LOW_HOLD;
                    hold_nxt  = HW'(1);
                end else if (hold == HOLD_END) begin
                    state_nxt = CK_HIGH_FREE;
                end else begin
                    hold_nxt = hold + 1'b1;
                end
            end
            CK_HIGH_FREE: begin
                if (!cke) begin
                    state_nxt = CK_LOW_HOLD;
                    hold_nxt  = HW'(1);
                end
            end
            default: begin
                state_nxt = CK_INIT;
            end
        endcase
    end

endmodule

// File: rtl/ddr2_spacing_monitor.sv
module ddr2_spacing_monitor
    import ddr2_mon_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter int CK_PERIOD_PS = 3000,
    parameter int TRP_PS       = 15000,
    parameter int TWTR_PS      = 7500,
    parameter int WR_CYC       = 3,
    parameter int BA_W         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic                 ap,
    output logic [NUM_RULES-1:0] viol,
    output logic [NUM_RULES-1:0] err_sticky
);

    localparam int RP_CYC  = ceil_div(TRP_PS, CK_PERIOD_PS);
    localparam int WTR_CYC = max2(2, ceil_div(TWTR_PS, CK_PERIOD_PS));
    localparam int DAL_CYC = WR_CYC + RP_CYC;
    localparam int CCD_CYC = 2;
    localparam int MRD_CYC = 2;
    localparam int CKE_CYC = 3;
    localparam int CW      = $clog2(max2(max2(DAL_CYC, WTR_CYC), 2) + 1);

    if (CK_PERIOD_PS < 3000 || CK_PERIOD_PS > 8000) begin : g_bad_period
        $error("clock period %0d ps lies outside 3000..8000 ps", CK_PERIOD_PS);
    end

    cmd_e                 cmd;
    logic                 rp_hit, dal_hit, ccd_hit, wtr_hit, mrd_hit, cke_hit;
    logic [NUM_RULES-1:0] hits;

    ddr2_cmd_decode u_dec (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    ddr2_bank_timers #(
        .NUM_BANKS (NUM_BANKS),
        .BA_W      (BA_W),
        .CW        (CW),
        .RP_CYC    (RP_CYC),
        .DAL_CYC   (DAL_CYC)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .ba      (ba),
        .ap      (ap),
        .rp_hit  (rp_hit),
        .dal_hit (dal_hit)
    );

    ddr2_global_timers #(
        .CW      (CW),
        .CCD_CYC (CCD_CYC),
        .WTR_CYC (WTR_CYC),
        .MRD_CYC (MRD_CYC)
    ) u_glob (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .ccd_hit (ccd_hit),
        .wtr_hit (wtr_hit),
        .mrd_hit (mrd_hit)
    );

    ddr2_cke_fsm #(
        .MIN_CYC (CKE_CYC)
    ) u_cke (
        .clk     (clk),
        .rst_n   (rst_n),
        .cke     (cke),
        .cke_hit (cke_hit)
    );

    always_comb begin
        hits           = '0;
        hits[RULE_RP]  = rp_hit;
        hits[RULE_CCD] = ccd_hit;
        hits[RULE_WTR] = wtr_hit;
        hits[RULE_MRD] = mrd_hit;
        hits[RULE_CKE] = cke_hit;
        hits[RULE_DAL] = dal_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol       <= '0;
            err_sticky <= '0;
        end else begin
            viol       <= hits;
            err_sticky <= err_sticky | hits;
        end
    end

endmodule

// File: rtl/ddr2_spacing_monitor_chk.sv
module ddr2_spacing_monitor_chk
    import ddr2_mon_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cke,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic [NUM_RULES-1:0] viol,
    input logic [NUM_RULES-1:0] err_sticky
);

    logic [1:0] age;
    logic       col_cmd, mrs_cmd, any_cmd;

    always_ff @(posedge clk) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 1'b1;
    end

    assign col_cmd = cke && !cs_n && ras_n && !cas_n;
    assign mrs_cmd = cke && !cs_n && !ras_n && !cas_n && !we_n;
    assign any_cmd = cke && !cs_n && !(ras_n && cas_n);

    a_r9_sticky_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> ((err_sticky & $past(err_sticky)) == $past(err_sticky)));

    a_r9_pulse_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_sticky & viol) == viol));

    a_r1_quiet_when_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke) |=> ((viol & ~(NUM_RULES'(1) << RULE_CKE)) == '0));

    a_r1_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n) |=> ((viol & ~(NUM_RULES'(1) << RULE_CKE)) == '0));

    a_r4_back_to_back_column: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && col_cmd && $past(col_cmd)) |=> viol[RULE_CCD]);

    a_r6_command_after_mode_set: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && any_cmd && $past(mrs_cmd)) |=> viol[RULE_MRD]);

    a_r7_cke_toggle_each_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && (cke != $past(cke)) && ($past(cke) != $past(cke, 2)))
            |=> viol[RULE_CKE]);

endmodule

bind ddr2_spacing_monitor ddr2_spacing_monitor_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .viol       (viol),
    .err_sticky (err_sticky)
);

// File: tb/ddr2_spacing_monitor_bench.sv
module ddr2_spacing_monitor_bench;

    localparam int CK_PS  = 3000;
    localparam int TRP    = 15000;
    localparam int TWTR   = 7500;
    localparam int WRC    = 3;
    localparam int N_RP   = (TRP + CK_PS - 1) / CK_PS;
    localparam int N_WTR  = ((TWTR + CK_PS - 1) / CK_PS > 2) ? (TWTR + CK_PS - 1) / CK_PS : 2;
    localparam int N_DAL  = WRC + N_RP;

    localparam logic [2:0] C_MRS = 3'b000;
    localparam logic [2:0] C_REF = 3'b001;
    localparam logic [2:0] C_PRE = 3'b010;
    localparam logic [2:0] C_ACT = 3'b011;
    localparam logic [2:0] C_WR  = 3'b100;
    localparam logic [2:0] C_RD  = 3'b101;
    localparam logic [2:0] C_RSV = 3'b110;
    localparam logic [2:0] C_NOP = 3'b111;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       cs_n = 1'b1;
    logic       ras_n = 1'b1;
    logic       cas_n = 1'b1;
    logic       we_n = 1'b1;
    logic [1:0] ba = '0;
    logic       ap = 1'b0;
    logic [5:0] viol;
    logic [5:0] err_sticky;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [5:0] v;
        logic [5:0] e;
        string      tag;
    } exp_t;
    exp_t q[$];

    int cyc;
    int last_pre[4];
    int last_apw[4];
    int last_col, last_wr, last_mrs, last_edge;
    logic lvl;
    logic [5:0] exp_err;

    always #5 clk = ~clk;

    ddr2_spacing_monitor u_ddr2_spacing_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .ba         (ba),
        .ap         (ap),
        .viol       (viol),
        .err_sticky (err_sticky)
    );

    task automatic model_reset();
        cyc = 0;
        for (int i = 0; i < 4; i++) begin
            last_pre[i] = -1000;
            last_apw[i] = -1000;
        end
        last_col  = -1000;
        last_wr   = -1000;
        last_mrs  = -1000;
        last_edge = -1000;
        lvl       = 1'b1;
        exp_err   = '0;
    endtask

    // Driver: computes the expected result of one cycle and pushes it.
    task automatic step(input string tag, input logic cs, input logic [2:0] c,
                        input logic [1:0] b, input logic a, input logic ck);
        logic [5:0] e;
        logic       valid;
        @(negedge clk);
        e = '0;
        if (ck != lvl) begin
            if (cyc - last_edge < 3) e[4] = 1'b1;   // R7
            last_edge = cyc;
            lvl = ck;
        end
        valid = ck && !cs && (c != C_NOP) && (c != C_RSV);   // R1
        if (valid) begin
            if (cyc - last_mrs < 2) e[3] = 1'b1;    // R6
            case (c)
                C_PRE: begin
                    if (a) for (int i = 0; i < 4; i++) last_pre[i] = cyc;  // R3
                    else last_pre[b] = cyc;
                end
                C_ACT: begin
                    if (cyc - last_pre[b] < N_RP)  e[0] = 1'b1;   // R2
                    if (cyc - last_apw[b] < N_DAL) e[5] = 1'b1;   // R8
                end
                C_WR, C_RD: begin
                    if (cyc - last_col < 2) e[1] = 1'b1;          // R4
                    if (c == C_RD && cyc - last_wr < N_WTR) e[2] = 1'b1;  // R5
                    if (c == C_WR) begin
                        last_wr = cyc;
                        if (a) last_apw[b] = cyc;
                    end
                    last_col = cyc;
                end
                C_MRS: last_mrs = cyc;
                default: ;
            endcase
        end
        exp_err = exp_err | e;   // R9
        q.push_back('{v: e, e: exp_err, tag: tag});
        cyc++;
        cs_n = cs;
        {ras_n, cas_n, we_n} = c;
        ba = b;
        ap = a;
        cke = ck;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step("idle", 1'b1, C_NOP, 2'd0, 1'b0, lvl);
    endtask

    task automatic cmd(input string tag, input logic [2:0] c, input logic [1:0] b, input logic a);
        step(tag, 1'b0, c, b, a, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP; ap = 1'b0; ba = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (viol !== 6'd0 || err_sticky !== 6'd0) begin
            failures++;
            $display("FAIL R9 reset state: viol=%b err=%b expected 000000/000000", viol, err_sticky);
        end
        model_reset();
        rst_n = 1'b1;
    endtask

    // Monitor: pops one expectation per cycle, after the edge has settled.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0 && rst_n) begin
                exp_t x;
                x = q.pop_front();
                checks++;
                if (viol !== x.v || err_sticky !== x.e) begin
                    failures++;
                    $display("FAIL %s: viol=%b err=%b expected viol=%b err=%b",
                             x.tag, viol, err_sticky, x.v, x.e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        idle(3);

        // R2: same-bank activate one cycle early, then exactly at the limit
        cmd("R2 pre b0", C_PRE, 2'd0, 1'b0);
        idle(N_RP - 2);
        cmd("R2 act early", C_ACT, 2'd0, 1'b0);
        cmd("R2 pre b1", C_PRE, 2'd1, 1'b0);
        idle(N_RP - 1);
        cmd("R2 act at limit", C_ACT, 2'd1, 1'b0);
        cmd("R2 pre b2", C_PRE, 2'd2, 1'b0);
        cmd("R2 act other bank", C_ACT, 2'd3, 1'b0);
        idle(N_RP);

        // R3: precharge-all arms every bank
        cmd("R3 pre all", C_PRE, 2'd0, 1'b1);
        idle(1);
        cmd("R3 act b3", C_ACT, 2'd3, 1'b0);
        idle(N_RP);

        // R1: deselect and reserved code between column commands
        cmd("R1 rd", C_RD, 2'd0, 1'b0);
        step("R1 deselected rd", 1'b1, C_RD, 2'd0, 1'b0, 1'b1);
        cmd("R1 reserved code", C_RSV, 2'd0, 1'b0);
        idle(3);

        // R4 / R5
        cmd("R4 rd", C_RD, 2'd0, 1'b0);
        cmd("R4 rd back-to-back", C_RD, 2'd1, 1'b0);
        idle(3);
        cmd("R5 wr", C_WR, 2'd0, 1'b0);
        idle(1);
        cmd("R5 rd at 2", C_RD, 2'd0, 1'b0);
        idle(3);
        cmd("R5 wr", C_WR, 2'd0, 1'b0);
        idle(N_WTR - 1);
        cmd("R5 rd at limit", C_RD, 2'd0, 1'b0);
        idle(1);
        cmd("R4 wr at 2", C_WR, 2'd2, 1'b0);
        idle(3);

        // R8: write with auto-precharge then activate
        cmd("R8 wr ap b1", C_WR, 2'd1, 1'b1);
        idle(N_DAL - 2);
        cmd("R8 act early", C_ACT, 2'd1, 1'b0);
        cmd("R8 wr ap b2", C_WR, 2'd2, 1'b1);
        idle(N_DAL - 1);
        cmd("R8 act at limit", C_ACT, 2'd2, 1'b0);
        idle(3);

        // R6
        cmd("R6 mrs", C_MRS, 2'd0, 1'b0);
        cmd("R6 act after mrs", C_ACT, 2'd0, 1'b0);
        idle(2);
        cmd("R6 mrs", C_MRS, 2'd0, 1'b0);
        cmd("R6 mrs after mrs", C_MRS, 2'd0, 1'b0);
        idle(1);
        cmd("R6 ref at 2", C_REF, 2'd0, 1'b0);
        idle(3);

        // R1 with CKE low: spacing-breaking commands are ignored
        cmd("R1 pre b0", C_PRE, 2'd0, 1'b0);
        step("R1 act cke low", 1'b0, C_ACT, 2'd0, 1'b0, 1'b0);
        step("R1 rd cke low", 1'b0, C_RD, 2'd0, 1'b0, 1'b0);
        step("R1 rd cke low", 1'b0, C_RD, 2'd0, 1'b0, 1'b0);
        step("R1 mrs cke low", 1'b0, C_MRS, 2'd0, 1'b0, 1'b0);
        step("R7 cke up at 4", 1'b1, C_NOP, 2'd0, 1'b0, 1'b1);
        idle(3);

        // R7: short low pulse, short high pulse
        step("R7 cke down", 1'b1, C_NOP, 2'd0, 1'b0, 1'b0);
        step("R7 low 1", 1'b1, C_NOP, 2'd0, 1'b0, 1'b0);
        step("R7 rise at 2", 1'b1, C_NOP, 2'd0, 1'b0, 1'b1);
        step("R7 fall at 1", 1'b1, C_NOP, 2'd0, 1'b0, 1'b0);
        idle(2);
        step("R7 rise at 3", 1'b1, C_NOP, 2'd0, 1'b0, 1'b1);
        idle(4);

        // R9: reset clears sticky bits
        repeat (2) @(negedge clk);
        do_reset();
        idle(2);
        cmd("R9 rd", C_RD, 2'd0, 1'b0);
        idle(2);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule